// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. A single carrier counter runs as a symmetric triangle. It counts up from zero to the programmed period and back down. Each phase compares its own duty value against the carrier, which gives centre-aligned pulses. Every phase has a high-side gate and a low-side gate. A dead-band stage keeps the two gates of a leg apart by a programmable number of clock cycles at every switching edge. It also swallows any pulse that is too short to survive that gap.

Software programs the block through a single write port. The period and the three duty values are double-buffered. They move into the active registers once per carrier cycle, either at the trough or at the crest, as a control bit selects. While the block is stopped, they move on every cycle. Interrupt pulses mark the carrier crest and the carrier trough, and each has its own enable. A conversion-start pulse for an analog-to-digital converter follows the trough. It comes after a programmable delay and can be limited to one trough out of every N+1.

The write port follows a valid/ready handshake. `wr_ready` is held high at all times, so the port never applies back-pressure. A write is taken on every rising clock edge where `wr_valid` is high. Gate, interrupt and trigger outputs are plain level or pulse signals with no handshake.

Top module: `pwm3_gen`

## Requirements
- R1: After reset, and whenever the run bit (bit 0 of the control register at address 0) is clear, all six gates, both interrupts and the trigger stay low. Registers can still be written while stopped.
- R2: The high-side and low-side gates of one phase are never high in the same cycle. When the dead time is non-zero, a gate never rises in the cycle right after its partner was high.
- R3: The period P is at address 1, the dead time T at address 2, and the duties D for phases U, V and W at addresses 5, 6 and 7. The carrier cycle lasts 2P clocks. For 1 <= D <= P, the high-side pulse of a phase lasts 2D-1-T cycles per carrier cycle and the low-side pulse lasts 2P-2D+1-T cycles.
- R4: If 2D-1 <= T, the high-side gate of that phase stays low. The low-side gate still pulses for 2P-2D+1-T cycles.
- R5: D = 0 holds the high-side gate low and the low-side gate high without a break. D > P holds the high-side gate high and the low-side gate low without a break.
- R6: With control bit 1 clear, a duty written during a carrier cycle takes effect only after the next trough. The low-side pulse that follows the write still has the old width.
- R7: With control bit 1 set, a duty written after a crest takes effect only at the next crest. The high-side pulse centred on the trough in between keeps the old width.
- R8: With control bit 2 set, `crest_irq` pulses for one cycle, exactly once per carrier cycle. With bit 2 clear, it never pulses.
- R9: With control bit 3 set, `trough_irq` pulses for one cycle, exactly once per carrier cycle. With bit 3 clear, it never pulses. `trough_irq` and `crest_irq` are never high together.
- R10: The trigger delay value L sits at address 3 and must be below 2P. `adc_trig` pulses for one cycle, L+1 cycles after the trough interrupt pulse of a trough that launches a conversion.
- R11: The skip count S sits at address 4, in its low four bits. A conversion is launched on one trough out of every S+1, so successive `adc_trig` pulses are (S+1)*2P cycles apart.
- R12: `wr_ready` is always high, and a write with `wr_valid` high is accepted on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accept, always high |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| gate_hi | output | 3 | High-side gates, bit 0 = U, 1 = V, 2 = W |
| gate_lo | output | 3 | Low-side gates, same bit order |
| crest_irq | output | 1 | One-cycle pulse after the carrier crest |
| trough_irq | output | 1 | One-cycle pulse after the carrier trough |
| adc_trig | output | 1 | One-cycle converter start pulse |

## Verification
The hardest behaviour to reach from the ports is the double buffering. A duty write has to fall in a known half of the carrier cycle, and the pulse right before the transfer point must be told apart from the pulse right after it. The stimulus waits for a trough or crest interrupt pulse, writes the new duty a cycle later, and queues two expected widths: the old one for the next pulse and the new one for the pulse after it. The monitor measures consecutive pulses from rising to falling edge. It therefore shows a write that takes effect one half cycle too early, or one transfer point too late.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;

  // register addresses of the write port
  localparam int ADR_CTRL    = 0;
  localparam int ADR_PERIOD  = 1;
  localparam int ADR_DEAD    = 2;
  localparam int ADR_ADC_DLY = 3;
  localparam int ADR_ADC_SKP = 4;
  localparam int ADR_DUTY0   = 5;

  // control word, bit 0 is run
  typedef struct packed {
    logic trough_ie;
    logic crest_ie;
    logic load_at_crest;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm3_regs.sv
`timescale 1ns/1ps
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int NPH    = 3,
  parameter int CNT_W  = 16,
  parameter int DT_W   = 16,
  parameter int DLY_W  = 16,
  parameter int SKIP_W = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      crest_evt,
  input  logic                      trough_evt,
  output ctrl_t                     ctrl,
  output logic [CNT_W-1:0]          act_period,
  output logic [DT_W-1:0]           dead,
  output logic [DLY_W-1:0]          adc_delay,
  output logic [SKIP_W-1:0]         adc_skip,
  output logic [NPH-1:0][CNT_W-1:0] act_duty
);

  logic [CNT_W-1:0]          buf_period;
  logic [NPH-1:0][CNT_W-1:0] buf_duty;
  logic                      load_now;

  function automatic logic hit(input int a);
    return wr_en && (wr_addr == ADDR_W'(a));
  endfunction

  // shadow to active transfer: every cycle while stopped, else once per carrier
  always_comb load_now = !ctrl.run || (ctrl.load_at_crest ? crest_evt : trough_evt);

  // directly acting registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      dead      <= '0;
      adc_delay <= '0;
      adc_skip  <= '0;
    end else begin
      if (hit(ADR_CTRL))    ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (hit(ADR_DEAD))    dead      <= wr_data[DT_W-1:0];
      if (hit(ADR_ADC_DLY)) adc_delay <= wr_data[DLY_W-1:0];
      if (hit(ADR_ADC_SKP)) adc_skip  <= wr_data[SKIP_W-1:0];
    end
  end

  // shadow registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_period <= '0;
      buf_duty   <= '0;
    end else begin
      if (hit(ADR_PERIOD)) buf_period <= wr_data[CNT_W-1:0];
      for (int i = 0; i < NPH; i++) begin
        if (hit(ADR_DUTY0 + i)) buf_duty[i] <= wr_data[CNT_W-1:0];
      end
    end
  end

  // active registers seen by the carrier and the comparators
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_period <= '0;
      act_duty   <= '0;
    end else if (load_now) begin
      act_period <= buf_period;
      act_duty   <= buf_duty;
    end
  end

endmodule

// File: rtl/pwm3_carrier.sv
`timescale 1ns/1ps
module pwm3_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             crest_evt,
  output logic             trough_evt
);

  logic going_up;
  logic at_top;
  logic halted;

  always_comb begin
    halted     = (period == '0);
    at_top     = going_up && (cnt >= period);
    crest_evt  = en && !halted && at_top;
    trough_evt = en && !halted && !going_up && (cnt == '0);
  end

  // symmetric triangle 0 .. period .. 0, 2*period clocks per cycle
  always_ff @(posedge clk) begin
    if (!rst_n || !en || halted) begin
      cnt      <= '0;
      going_up <= 1'b1;
    end else if (going_up) begin
      if (at_top) begin
        going_up <= 1'b0;
        cnt      <= cnt - CNT_W'(1);
      end else begin
        cnt      <= cnt + CNT_W'(1);
      end
    end else begin
      if (cnt == '0) begin
        going_up <= 1'b1;
        cnt      <= CNT_W'(1);
      end else begin
        cnt      <= cnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/pwm3_deadband.sv
`timescale 1ns/1ps
module pwm3_deadband #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic [DT_W-1:0]  dead,
  output logic             hi,
  output logic             lo
);

  logic            raw;
  logic            raw_q;
  logic [DT_W-1:0] held;   // cycles raw_q has kept its level, saturating
  logic            settled;

  always_comb begin
    raw     = en && (duty > cnt);
    settled = (held >= dead);
    hi      = en && raw_q && settled;
    lo      = en && !raw_q && settled;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      raw_q <= 1'b0;
      held  <= '0;
    end else begin
      raw_q <= raw;
      if (raw != raw_q)     held <= '0;
      else if (held != '1) held <= held + DT_W'(1);
    end
  end

endmodule

// File: rtl/pwm3_trigger.sv
`timescale 1ns/1ps
module pwm3_trigger #(
  parameter int DLY_W  = 16,
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              crest_evt,
  input  logic              trough_evt,
  input  logic              crest_ie,
  input  logic              trough_ie,
  input  logic [DLY_W-1:0]  delay,
  input  logic [SKIP_W-1:0] skip,
  output logic              crest_irq,
  output logic              trough_irq,
  output logic              adc_trig
);

  logic [SKIP_W-1:0] skip_left;
  logic [DLY_W-1:0]  dly_left;
  logic              armed;
  logic              launch;

  always_comb launch = trough_evt && (skip_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      crest_irq  <= 1'b0;
      trough_irq <= 1'b0;
      adc_trig   <= 1'b0;
      skip_left  <= '0;
      dly_left   <= '0;
      armed      <= 1'b0;
    end else begin
      crest_irq  <= crest_evt && crest_ie;
      trough_irq <= trough_evt && trough_ie;
      adc_trig   <= armed && (dly_left == '0);
      if (trough_evt) begin
        skip_left <= (skip_left == '0) ? skip : skip_left - SKIP_W'(1);
      end
      if (launch) begin
        armed    <= 1'b1;
        dly_left <= delay;
      end else if (armed) begin
        if (dly_left == '0) armed    <= 1'b0;
        else                dly_left <= dly_left - DLY_W'(1);
      end
    end
  end

endmodule

// File: rtl/pwm3_gen.sv
`timescale 1ns/1ps
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int NPH    = 3,
  parameter int CNT_W  = 16,
  parameter int DT_W   = 16,
  parameter int DLY_W  = 16,
  parameter int SKIP_W = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NPH-1:0]    gate_hi,
  output logic [NPH-1:0]    gate_lo,
  output logic              crest_irq,
  output logic              trough_irq,
  output logic              adc_trig
);

  ctrl_t                     ctrl;
  logic [CNT_W-1:0]          act_period;
  logic [DT_W-1:0]           dead_val;
  logic [DLY_W-1:0]          adc_delay;
  logic [SKIP_W-1:0]         adc_skip;
  logic [NPH-1:0][CNT_W-1:0] act_duty;
  logic [CNT_W-1:0]          cnt;
  logic                      crest_evt;
  logic                      trough_evt;
  logic                      run_on;
  logic                      wr_en;

  always_comb begin
    wr_ready = 1'b1;
    wr_en    = wr_valid && wr_ready;
    run_on   = ctrl.run;
  end

  pwm3_regs #(
    .NPH(NPH), .CNT_W(CNT_W), .DT_W(DT_W), .DLY_W(DLY_W),
    .SKIP_W(SKIP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .crest_evt(crest_evt), .trough_evt(trough_evt),
    .ctrl(ctrl), .act_period(act_period), .dead(dead_val),
    .adc_delay(adc_delay), .adc_skip(adc_skip), .act_duty(act_duty)
  );

  pwm3_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst_n(rst_n), .en(run_on), .period(act_period),
    .cnt(cnt), .crest_evt(crest_evt), .trough_evt(trough_evt)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_leg
    pwm3_deadband #(.CNT_W(CNT_W), .DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .en(run_on), .cnt(cnt),
      .duty(act_duty[i]), .dead(dead_val),
      .hi(gate_hi[i]), .lo(gate_lo[i])
    );
  end

  pwm3_trigger #(.DLY_W(DLY_W), .SKIP_W(SKIP_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .en(run_on),
    .crest_evt(crest_evt), .trough_evt(trough_evt),
    .crest_ie(ctrl.crest_ie), .trough_ie(ctrl.trough_ie),
    .delay(adc_delay), .skip(adc_skip),
    .crest_irq(crest_irq), .trough_irq(trough_irq), .adc_trig(adc_trig)
  );

endmodule

// File: rtl/pwm3_gen_chk.sv
`timescale 1ns/1ps
module pwm3_gen_chk #(
  parameter int NPH  = 3,
  parameter int DT_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPH-1:0]  gate_hi,
  input logic [NPH-1:0]  gate_lo,
  input logic            crest_irq,
  input logic            trough_irq,
  input logic            adc_trig,
  input logic            wr_ready,
  input logic            run,
  input logic [DT_W-1:0] dead
);

  for (genvar i = 0; i < NPH; i++) begin : g_leg
    // R2
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[i] && gate_lo[i]));
    // R2
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dead != '0 && $rose(gate_lo[i])) |-> !$past(gate_hi[i]));
    // R2
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dead != '0 && $rose(gate_hi[i])) |-> !$past(gate_lo[i]));
  end

  // R1
  idle_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (gate_hi == '0 && gate_lo == '0));

  // R1
  idle_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> (!crest_irq && !trough_irq && !adc_trig));

  // R8
  crest_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crest_irq |=> !crest_irq);

  // R9
  irq_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(crest_irq && trough_irq));

  // R10
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> !adc_trig);

  // R12
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);

endmodule

bind pwm3_gen pwm3_gen_chk #(.NPH(NPH), .DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .crest_irq(crest_irq), .trough_irq(trough_irq), .adc_trig(adc_trig),
  .wr_ready(wr_ready), .run(run_on), .dead(dead_val)
);

// File: tb/pwm3_gen_tb.sv
`timescale 1ns/1ps
module pwm3_gen_tb;

  localparam int P   = 20;
  localparam int DT  = 3;
  localparam int WIN = 3 * 2 * P;

  localparam int K_PW_HI     = 0;
  localparam int K_PW_LO     = 1;
  localparam int K_CNT_HI    = 2;
  localparam int K_CNT_LO    = 3;
  localparam int K_CNT_CREST = 4;
  localparam int K_CNT_TRGH  = 5;
  localparam int K_ADC_DLY   = 6;
  localparam int K_ADC_GAP   = 7;
  localparam int K_CNT_ANY   = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  gate_hi;
  logic [2:0]  gate_lo;
  logic        crest_irq;
  logic        trough_irq;
  logic        adc_trig;

  always #2.5 clk = ~clk;

  pwm3_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .crest_irq(crest_irq), .trough_irq(trough_irq), .adc_trig(adc_trig)
  );

  typedef struct {
    int    kind;
    int    ph;
    int    exp;
    string tag;
  } item_t;

  item_t sbq[$];
  bit    mon_busy = 1'b0;
  bit    finished = 1'b0;
  int    n_cmp    = 0;
  int    n_bad    = 0;
  int    overlaps = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(input int kind, input int ph);
    case (kind)
      K_PW_HI, K_CNT_HI: return gate_hi[ph];
      K_PW_LO, K_CNT_LO: return gate_lo[ph];
      K_CNT_CREST:       return crest_irq;
      K_CNT_TRGH:        return trough_irq;
      K_CNT_ANY:         return |{gate_hi, gate_lo, crest_irq, trough_irq, adc_trig};
      default:           return 1'b0;
    endcase
  endfunction

  // driver side of the scoreboard
  task automatic expect_item(input int kind, input int ph, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.ph = ph; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    while (sbq.size() != 0 || mon_busy) @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = 3'(addr);
    wr_data  = 16'(data);
    check("R12 write accepted", int'(wr_ready), 1);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side: measures what each queued item asks for
  task automatic measure(input item_t it, output int val);
    val = 0;
    case (it.kind)
      K_PW_HI, K_PW_LO: begin
        while (pick(it.kind, it.ph)) @(negedge clk);
        while (!pick(it.kind, it.ph)) @(negedge clk);
        while (pick(it.kind, it.ph)) begin val++; @(negedge clk); end
      end
      K_ADC_DLY: begin
        while (!trough_irq) @(negedge clk);
        do begin @(negedge clk); val++; end while (!adc_trig);
      end
      K_ADC_GAP: begin
        while (!adc_trig) @(negedge clk);
        do begin @(negedge clk); val++; end while (!adc_trig);
      end
      default: begin
        for (int k = 0; k < WIN; k++) begin
          @(negedge clk);
          if (pick(it.kind, it.ph)) val++;
        end
      end
    endcase
  endtask

  initial begin
    forever begin
      while (sbq.size() == 0) @(negedge clk);
      mon_busy = 1'b1;
      begin
        item_t it;
        int    v;
        it = sbq.pop_front();
        measure(it, v);
        check(it.tag, v, it.exp);
      end
      mon_busy = 1'b0;
    end
  end

  // R2 shoot-through observed at the ports throughout the run
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (gate_hi & gate_lo) != 3'b000) overlaps++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    wr_valid = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs after reset", int'({gate_hi, gate_lo, crest_irq, trough_irq, adc_trig}), 0);

    wr(1, P);
    wr(2, DT);
    wr(5, 8);   // U: 2*8-1-3 = 12 high, 40-15-3 = 22 low
    wr(6, 2);   // V: raw pulse of 3 swallowed
    wr(7, 0);   // W: 0 %
    wr(3, 5);
    wr(4, 0);
    idle(2);
    // R1 still quiet while stopped
    check("R1 outputs while stopped", int'({gate_hi, gate_lo, crest_irq, trough_irq, adc_trig}), 0);

    wr(0, 4'b1101);
    idle(100);
    expect_item(K_PW_HI,     0, 12,  "R3 high-side width U");
    expect_item(K_PW_LO,     0, 22,  "R3 low-side width U");
    expect_item(K_CNT_HI,    0, 36,  "R3 high cycles U in 3 carriers");
    expect_item(K_CNT_HI,    1, 0,   "R4 suppressed high-side V");
    expect_item(K_PW_LO,     1, 34,  "R4 low-side width V");
    expect_item(K_CNT_HI,    2, 0,   "R5 0% high-side W");
    expect_item(K_CNT_LO,    2, WIN, "R5 0% low-side W");
    expect_item(K_CNT_CREST, 0, 3,   "R8 crest pulses per 3 carriers");
    expect_item(K_CNT_TRGH,  0, 3,   "R9 trough pulses per 3 carriers");
    expect_item(K_ADC_DLY,   0, 6,   "R10 trigger delay 5");
    drain();

    // R5 100 %
    wr(7, P + 1);
    idle(80);
    expect_item(K_CNT_HI, 2, WIN, "R5 100% high-side W");
    expect_item(K_CNT_LO, 2, 0,   "R5 100% low-side W");
    drain();

    // R11 one trough in three
    wr(4, 2);
    idle(200);
    expect_item(K_ADC_GAP, 0, 3 * 2 * P, "R11 trigger spacing skip 2");
    expect_item(K_ADC_GAP, 0, 3 * 2 * P, "R11 trigger spacing skip 2 again");
    drain();
    wr(4, 0);
    wr(3, 0);
    idle(100);
    expect_item(K_ADC_DLY, 0, 1,     "R10 trigger delay 0");
    expect_item(K_ADC_GAP, 0, 2 * P, "R11 trigger spacing skip 0");
    drain();

    // R8 / R9 enables
    wr(0, 4'b1001);
    idle(4);
    expect_item(K_CNT_CREST, 0, 0, "R8 crest masked");
    expect_item(K_CNT_TRGH,  0, 3, "R9 trough kept");
    drain();
    wr(0, 4'b0101);
    idle(4);
    expect_item(K_CNT_TRGH,  0, 0, "R9 trough masked");
    expect_item(K_CNT_CREST, 0, 3, "R8 crest kept");
    drain();
    wr(0, 4'b1101);
    idle(4);

    // R6 transfer at trough
    while (!trough_irq) @(negedge clk);
    expect_item(K_PW_LO, 0, 22, "R6 low-side keeps old duty");
    expect_item(K_PW_LO, 0, 28, "R6 low-side after trough load");
    wr(5, 5);
    drain();

    // R7 transfer at crest
    wr(0, 4'b1111);
    idle(4);
    while (!crest_irq) @(negedge clk);
    expect_item(K_PW_HI, 0, 6,  "R7 high-side keeps old duty");
    expect_item(K_PW_HI, 0, 14, "R7 high-side after crest load");
    wr(5, 9);
    drain();

    // R1 stop
    wr(0, 0);
    idle(3);
    expect_item(K_CNT_ANY, 0, 0, "R1 all quiet after stop");
    drain();

    check("R2 gate overlap cycles", overlaps, 0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule